// File: doc/BRIEF.md
# Serial Port Event Request Unit

This unit sits beside a FIFO-based serial port. It turns the port's FIFO fill levels and event pulses into one shared interrupt line and two DMA request lines. It has six event sources. Two of them are live levels taken from the FIFO counts: transmit FIFO low and receive FIFO filled. The other four are sticky flags set by pulses from the serial engine: transmit stopped, receive error, break seen and receive data ready. Software sees all six in a status vector and enables each source separately.

A synchronous-mode input narrows the interrupt to the two FIFO sources. A DMA-mode input moves those two FIFO sources off the interrupt line and onto the transmit and receive DMA request outputs. Each DMA request follows its FIFO level against its trigger and drops by itself once the FIFO has been served. No source ever drives an interrupt and a DMA request in the same cycle.

Top module: `uart_evt_req_unit`

## Requirements
- R1: Status bit 0 (transmit FIFO low) reads 1 in the same cycle whenever `tx_count_i` <= `tx_trig_i`, and 0 otherwise.
- R2: Status bit 3 (receive FIFO filled) reads 1 in the same cycle whenever `rx_count_i` >= `rx_trig_i`, and 0 otherwise.
- R3: A one-cycle pulse on an `evt_i` bit sets a sticky status bit from the next clock edge, and the bit stays set. The mapping is evt_i[0] to bit 1 (transmit stopped), evt_i[1] to bit 2 (receive error), evt_i[2] to bit 4 (break) and evt_i[3] to bit 5 (data ready).
- R4: A sticky status bit clears only on a write (`stat_wr_i`) with a 0 in its `stat_wdata_i` position, after an earlier read strobe (`stat_rd_i`) saw that bit at 1. A write of 0 with no such read, or a write of 1, leaves the bit set.
- R5: `irq_o` is registered. One clock after a change, it equals the OR of the status bits whose `src_en_i` bit is 1, after the masks of R6 and R9.
- R6: While `sync_mode_i` is 1, status bits 1, 2, 4 and 5 cannot assert `irq_o`, whatever their enables.
- R7: While `dma_mode_i` is 1 and `src_en_i[0]` is 1, `tx_dma_req_o` follows status bit 0 with one clock of delay. It therefore drops one clock after `tx_count_i` rises above `tx_trig_i`.
- R8: While `dma_mode_i` is 1 and `src_en_i[3]` is 1, `rx_dma_req_o` follows status bit 3 with one clock of delay. It therefore drops one clock after `rx_count_i` falls below `rx_trig_i`.
- R9: While `dma_mode_i` is 1, status bits 0 and 3 do not contribute to `irq_o`. While `dma_mode_i` is 0, both DMA requests are 0 one clock later.
- R10: After reset, `irq_o`, both DMA requests and status bits 1, 2, 4 and 5 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 selects synchronous mode (only the FIFO sources can interrupt) |
| dma_mode_i | input | 1 | 1 routes the FIFO sources to the DMA requests |
| src_en_i | input | 6 | Per-source enable, in the same bit order as the status vector |
| tx_count_i | input | CNT_W (5) | Transmit FIFO entry count, 0..16 |
| tx_trig_i | input | CNT_W (5) | Transmit trigger level |
| rx_count_i | input | CNT_W (5) | Receive FIFO entry count, 0..16 |
| rx_trig_i | input | CNT_W (5) | Receive trigger level |
| evt_i | input | 4 | Set pulses for the sticky flags: stop, error, break, ready |
| stat_rd_i | input | 1 | Status read strobe; arms the clearing of bits it sees at 1 |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 6 | Status write data; a 0 clears an armed sticky bit |
| status_o | output | 6 | Source status vector |
| irq_o | output | 1 | Shared interrupt request, registered |
| tx_dma_req_o | output | 1 | Transmit DMA request, registered |
| rx_dma_req_o | output | 1 | Receive DMA request, registered |

## Verification
The threshold compare is driven at the trigger value and one step on each side of it. These points separate an inclusive comparison from a strict one on both FIFO directions. The sticky flags get a bare write of 0, then a read followed by a write of 1, then a read followed by a write of 0, so the read-arming rule is separated from a plain write-to-clear. The interrupt and DMA paths are tried with the same FIFO level in three settings: plain mode, synchronous mode and DMA mode. Each setting shows which mask removes which source. The DMA requests are then followed as the counts move back across the trigger, which shows that the requests drop without any other action.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int unsigned N_SRC    = 6;
  localparam int unsigned N_STICKY = 4;
  localparam int unsigned SRC_TXE  = 0;
  localparam int unsigned SRC_TXS  = 1;
  localparam int unsigned SRC_RER  = 2;
  localparam int unsigned SRC_RXF  = 3;
  localparam int unsigned SRC_BRK  = 4;
  localparam int unsigned SRC_RDY  = 5;

  // status bit that each sticky flag occupies
  localparam int unsigned STICKY_POS [N_STICKY] = '{SRC_TXS, SRC_RER, SRC_BRK, SRC_RDY};

  localparam logic [N_SRC-1:0] FIFO_SRC_MASK = N_SRC'((1 << SRC_TXE) | (1 << SRC_RXF));
endpackage

// File: rtl/uart_evt_level_cmp.sv
module uart_evt_level_cmp #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  output logic             tx_low_o,
  output logic             rx_fill_o
);
  assign tx_low_o  = (tx_count_i <= tx_trig_i);
  assign rx_fill_o = (rx_count_i >= rx_trig_i);
endmodule

// File: rtl/uart_evt_flag_bank.sv
module uart_evt_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, armed_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic clr;
    assign clr = wr_i && !wdata_i[g] && armed_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g]  <= 1'b0;
        armed_q[g] <= 1'b0;
      end else if (set_i[g]) begin
        flag_q[g]  <= 1'b1;       // new event wins over a clear
        armed_q[g] <= 1'b0;
      end else if (clr) begin
        flag_q[g]  <= 1'b0;
        armed_q[g] <= 1'b0;
      end else if (rd_i && flag_q[g]) begin
        armed_q[g] <= 1'b1;
      end
    end

    assert_sticky_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[g] && !(wr_i && !wdata_i[g]) |=> flag_q[g]);

    assert_clear_by_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q[g]) |-> $past(wr_i && !wdata_i[g]));

    assert_set_by_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_evt_router.sv
module uart_evt_router
  import uart_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_mode_i,
  input  logic             dma_mode_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o,
  output logic             tx_dma_o,
  output logic             rx_dma_o
);
  logic [N_SRC-1:0] keep_sync, drop_dma, irq_vec;
  logic irq_q, tx_dma_q, rx_dma_q;

  assign keep_sync = sync_mode_i ? FIFO_SRC_MASK : '1;
  assign drop_dma  = dma_mode_i  ? FIFO_SRC_MASK : '0;
  assign irq_vec   = src_i & en_i & keep_sync & ~drop_dma;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      tx_dma_q <= 1'b0;
      rx_dma_q <= 1'b0;
    end else begin
      irq_q    <= |irq_vec;
      tx_dma_q <= dma_mode_i && en_i[SRC_TXE] && src_i[SRC_TXE];
      rx_dma_q <= dma_mode_i && en_i[SRC_RXF] && src_i[SRC_RXF];
    end
  end

  assign irq_o    = irq_q;
  assign tx_dma_o = tx_dma_q;
  assign rx_dma_o = rx_dma_q;

  assert_irq_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(src_i & en_i)));

  assert_sync_masks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i && !dma_mode_i && !(|(src_i & en_i & FIFO_SRC_MASK)) |=> !irq_o);

  assert_tx_dma_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_i[SRC_TXE] |=> !tx_dma_o);

  assert_rx_dma_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_i[SRC_RXF] |=> !rx_dma_o);

  assert_no_dma_outside_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_mode_i |=> !tx_dma_o && !rx_dma_o);

  assert_fifo_src_not_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i && !(|(src_i & en_i & ~FIFO_SRC_MASK)) |=> !irq_o);
endmodule

// File: rtl/uart_evt_req_unit.sv
module uart_evt_req_unit
  import uart_evt_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_mode_i,
  input  logic                dma_mode_i,
  input  logic [N_SRC-1:0]    src_en_i,
  input  logic [CNT_W-1:0]    tx_count_i,
  input  logic [CNT_W-1:0]    tx_trig_i,
  input  logic [CNT_W-1:0]    rx_count_i,
  input  logic [CNT_W-1:0]    rx_trig_i,
  input  logic [N_STICKY-1:0] evt_i,
  input  logic                stat_rd_i,
  input  logic                stat_wr_i,
  input  logic [N_SRC-1:0]    stat_wdata_i,
  output logic [N_SRC-1:0]    status_o,
  output logic                irq_o,
  output logic                tx_dma_req_o,
  output logic                rx_dma_req_o
);
  logic tx_low, rx_fill;
  logic [N_STICKY-1:0] sticky_wdata, sticky_flags;
  logic [N_SRC-1:0] status;

  uart_evt_level_cmp #(.CNT_W(CNT_W)) i_level_cmp (
    .tx_count_i (tx_count_i),
    .tx_trig_i  (tx_trig_i),
    .rx_count_i (rx_count_i),
    .rx_trig_i  (rx_trig_i),
    .tx_low_o   (tx_low),
    .rx_fill_o  (rx_fill)
  );

  for (genvar g = 0; g < N_STICKY; g++) begin : g_map
    assign sticky_wdata[g]         = stat_wdata_i[STICKY_POS[g]];
    assign status[STICKY_POS[g]]   = sticky_flags[g];
  end
  assign status[SRC_TXE] = tx_low;
  assign status[SRC_RXF] = rx_fill;

  uart_evt_flag_bank #(.N(N_STICKY)) i_flag_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_i),
    .rd_i    (stat_rd_i),
    .wr_i    (stat_wr_i),
    .wdata_i (sticky_wdata),
    .flag_o  (sticky_flags)
  );

  uart_evt_router i_router (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_mode_i (sync_mode_i),
    .dma_mode_i  (dma_mode_i),
    .src_i       (status),
    .en_i        (src_en_i),
    .irq_o       (irq_o),
    .tx_dma_o    (tx_dma_req_o),
    .rx_dma_o    (rx_dma_req_o)
  );

  assign status_o = status;

  assert_level_status_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_i > tx_trig_i) |-> !status_o[SRC_TXE]);
endmodule

// File: tb/test_uart_evt_req_unit.sv
module test_uart_evt_req_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, dma_mode = 1'b0;
  logic [5:0] src_en = '0;
  logic [4:0] tx_count = 5'd8, tx_trig = 5'd4, rx_count = 5'd0, rx_trig = 5'd8;
  logic [3:0] evt = '0;
  logic stat_rd = 1'b0, stat_wr = 1'b0;
  logic [5:0] stat_wdata = '1;
  logic [5:0] status;
  logic irq, tx_dma, rx_dma;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_evt_req_unit i_uart_evt_req_unit (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .dma_mode_i(dma_mode),
    .src_en_i(src_en), .tx_count_i(tx_count), .tx_trig_i(tx_trig),
    .rx_count_i(rx_count), .rx_trig_i(rx_trig), .evt_i(evt),
    .stat_rd_i(stat_rd), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
    .status_o(status), .irq_o(irq), .tx_dma_req_o(tx_dma), .rx_dma_req_o(rx_dma)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance n rising edges, land on the falling edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_evt(logic [3:0] v);
    evt = v; step(1); evt = '0;
  endtask

  task automatic clear_sticky();
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    stat_wr = 1'b1; stat_wdata = '0; step(1); stat_wr = 1'b0; stat_wdata = '1;
  endtask

  task automatic t_reset();
    check("R10 irq", irq, 0);
    check("R10 dma", {tx_dma, rx_dma}, 0);
    check("R10 status", status, 0);
  endtask

  task automatic t_levels();
    tx_count = 5'd4; tx_trig = 5'd4; #1;
    check("R1 tx at trig", status[0], 1);
    tx_count = 5'd5; #1;
    check("R1 tx above trig", status[0], 0);
    tx_count = 5'd3; #1;
    check("R1 tx below trig", status[0], 1);
    rx_count = 5'd8; rx_trig = 5'd8; #1;
    check("R2 rx at trig", status[3], 1);
    rx_count = 5'd7; #1;
    check("R2 rx below trig", status[3], 0);
    rx_count = 5'd16; #1;
    check("R2 rx full", status[3], 1);
    tx_count = 5'd8; rx_count = 5'd0; step(1);
  endtask

  task automatic t_sticky();
    pulse_evt(4'b0010);
    check("R3 err set", status, 6'b000100);
    step(3);
    check("R3 err held", status, 6'b000100);
    pulse_evt(4'b1001);
    check("R3 stop+ready set", status, 6'b100110);
  endtask

  task automatic t_clear();
    stat_wr = 1'b1; stat_wdata = '0; step(1); stat_wr = 1'b0; stat_wdata = '1;
    check("R4 write0 without read", status, 6'b100110);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    stat_wr = 1'b1; stat_wdata = '1; step(1); stat_wr = 1'b0;
    check("R4 write1 after read", status, 6'b100110);
    stat_wr = 1'b1; stat_wdata = 6'b111011; step(1); stat_wr = 1'b0; stat_wdata = '1;
    check("R4 write0 after read clears bit2", status, 6'b100010);
    clear_sticky();
    check("R4 all cleared", status, 0);
  endtask

  task automatic t_irq();
    pulse_evt(4'b0100);
    step(1);
    check("R5 disabled source no irq", irq, 0);
    src_en = 6'b010000;
    step(1);
    check("R5 irq one clock after enable", irq, 1);
    src_en = 6'b000000;
    step(1);
    check("R5 irq drops after disable", irq, 0);
    src_en = 6'b010000;
    clear_sticky();
    step(1);
    check("R5 irq drops after clear", irq, 0);
    src_en = '0;
  endtask

  task automatic t_sync();
    sync_mode = 1'b1;
    src_en = 6'b110110;
    pulse_evt(4'b1111);
    step(1);
    check("R6 sync masks sticky sources", irq, 0);
    src_en = 6'b110111; tx_count = 5'd2;
    step(1);
    check("R6 sync keeps tx low source", irq, 1);
    tx_count = 5'd8; src_en = '0; sync_mode = 1'b0;
    clear_sticky();
    step(1);
  endtask

  task automatic t_tx_dma();
    dma_mode = 1'b1; src_en = 6'b000001;
    tx_count = 5'd4; tx_trig = 5'd4;
    step(1);
    check("R7 tx dma at trig", tx_dma, 1);
    check("R9 tx low not on irq in dma mode", irq, 0);
    tx_count = 5'd5;
    #1 check("R7 tx dma held until edge", tx_dma, 1);
    step(1);
    check("R7 tx dma drops above trig", tx_dma, 0);
    src_en = '0; dma_mode = 1'b0;
  endtask

  task automatic t_rx_dma();
    dma_mode = 1'b1; src_en = 6'b001000;
    rx_count = 5'd9; rx_trig = 5'd8;
    step(1);
    check("R8 rx dma above trig", rx_dma, 1);
    rx_count = 5'd8;
    step(1);
    check("R8 rx dma at trig", rx_dma, 1);
    rx_count = 5'd7;
    step(1);
    check("R8 rx dma drops below trig", rx_dma, 0);
    src_en = '0; dma_mode = 1'b0; rx_count = 5'd0;
  endtask

  task automatic t_dma_route();
    src_en = 6'b001001; tx_count = 5'd0; rx_count = 5'd12;
    step(1);
    check("R9 plain mode irq", irq, 1);
    check("R9 plain mode no dma", {tx_dma, rx_dma}, 0);
    dma_mode = 1'b1;
    step(1);
    check("R9 dma mode no irq", irq, 0);
    check("R9 dma mode both requests", {tx_dma, rx_dma}, 2'b11);
    src_en = 6'b001101;
    pulse_evt(4'b0010);
    step(1);
    check("R9 error still interrupts in dma mode", {irq, tx_dma, rx_dma}, 3'b111);
    dma_mode = 1'b0;
    step(1);
    check("R9 requests drop leaving dma mode", {tx_dma, rx_dma}, 0);
    src_en = '0; tx_count = 5'd8; rx_count = 5'd0;
    clear_sticky();
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_levels();
    t_sticky();
    t_clear();
    t_irq();
    t_sync();
    t_tx_dma();
    t_rx_dma();
    t_dma_route();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule